// File: doc/BRIEF.md
# GPIO Event Detector with Grouped Interrupts

This block watches 54 input pins and records selected events on each one in a sticky status register. Software picks, for every pin, any mix of six detection kinds: a synchronous rising edge, a synchronous falling edge, a high level, a low level, and a rising or falling edge seen on the raw, unsynchronized pin. Each recorded event sets one status bit. That bit stays set until software writes a 1 to it.

The status is reduced to three interrupt lines. Each line covers a fixed, contiguous range of pins. The middle line spans the boundary between the two 32-bit register banks. A host reaches the block through a simple 32-bit register port: a write strobe, a byte address and write data, with read data decoded combinationally from the address. Pin levels arrive already synchronized on one input. The raw levels arrive on a second input and feed the asynchronous edge path.

Top module: `gpio_event_unit`

## Requirements
- R1: With the synchronous-rise enable set for a pin (words at byte 0x4C for pins 0-31 and 0x50 for pins 32-53, bit = pin mod 32), a 0-to-1 change on its synchronized level sets its status bit at the next clock edge. A 1-to-0 change does not set it.
- R2: With the synchronous-fall enable set (0x58 / 0x5C), a 1-to-0 change on the synchronized level sets the status bit at the next clock edge.
- R3: With both the rise and fall enables set for one pin, each edge in either direction sets its status bit.
- R4: The status words (0x40 for pins 0-31, 0x44 for pins 32-53) are cleared by writing 1 per bit. A 0 bit in the write leaves that status bit unchanged.
- R5: With the high-level enable (0x64 / 0x68) or low-level enable (0x70 / 0x74) set and the synchronized pin at that level, the status bit is set at every clock edge. A clear write takes effect only after the level has gone away.
- R6: With the raw-rise enable (0x7C / 0x80) or raw-fall enable (0x88 / 0x8C) set, a matching change on the raw pin input sets the status bit at the third clock edge after the change, and not at the first.
- R7: A status bit that is already set stays set after all of its enables are cleared.
- R8: irq[0] is the OR of status for pins 0-27, irq[1] for pins 28-45, and irq[2] for pins 46-53.
- R9: When a new event and a clear write hit the same status bit at the same edge, the bit remains set.
- R10: After reset, every enable word and both status words read 0 and all interrupt lines are low.
- R11: Enable words read back the value written. Bits above pin 53 in the upper-bank words always read 0, and any address outside the map reads 0.
- R12: A pin whose six enables are all clear never sets its status bit, whatever its synchronized or raw inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe, acts at the rising clock edge |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_sync | input | 54 | Synchronized pin levels |
| pin_raw | input | 54 | Unsynchronized pin levels for raw edge detection |
| irq | output | 3 | Grouped interrupt lines |

## Verification
Each status bit is a single flop. A wrong next-state value therefore shows on the status readback and on the interrupt line of its group at the very next edge, or at the third edge for the raw-edge path. Faults in the previous-level or raw synchronizer flops show up as missed or spurious edge events. The bench drives one edge at a time and reads status straight after it to expose them. A mis-decoded enable word shows as a readback mismatch, or as status appearing on the wrong pin. Pins at both ends of every interrupt range and of each bank are used so that an off-by-one group mask changes the wrong irq bit.

// File: rtl/gev_pkg.sv
package gev_pkg;
  localparam int WORD_W        = 32;
  localparam int NUM_KINDS     = 6;
  // detection kind index into the enable array
  localparam int K_RISE        = 0;
  localparam int K_FALL        = 1;
  localparam int K_HIGH        = 2;
  localparam int K_LOW         = 3;
  localparam int K_ARISE       = 4;
  localparam int K_AFALL       = 5;
  // word (byte address / 4) placement
  localparam int STATUS_WORD   = 16;
  localparam int ENABLE_WORD0  = 19;
  localparam int ENABLE_STRIDE = 3;

  function automatic int enable_word(input int kind, input int bank);
    return ENABLE_WORD0 + kind * ENABLE_STRIDE + bank;
  endfunction
endpackage

// File: rtl/gev_enable_regs.sv
module gev_enable_regs
  import gev_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int IDX_W    = 6
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr,
  input  logic [IDX_W-1:0]                     widx,
  input  logic [WORD_W-1:0]                    wdata,
  output logic [NUM_KINDS-1:0][NUM_PINS-1:0]   en_q
);
  logic [NUM_KINDS-1:0][NUM_PINS-1:0] en_d;
  logic                               en_we;

  always_comb begin
    en_d  = en_q;
    en_we = 1'b0;
    for (int k = 0; k < NUM_KINDS; k++) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (wr && widx == IDX_W'(enable_word(k, p / WORD_W))) begin
          en_d[k][p] = wdata[p % WORD_W];
          en_we      = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  // R11
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en_q));
endmodule

// File: rtl/gev_detect.sv
module gev_detect
  import gev_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int IDX_W    = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_KINDS-1:0][NUM_PINS-1:0] en,
  input  logic [NUM_PINS-1:0]                pin_sync,
  input  logic [NUM_PINS-1:0]                pin_raw,
  input  logic                               wr,
  input  logic [IDX_W-1:0]                   widx,
  input  logic [WORD_W-1:0]                  wdata,
  output logic [NUM_PINS-1:0]                status_q
);
  logic [NUM_PINS-1:0] lvl_prev_q;
  logic [NUM_PINS-1:0] raw_s1_q, raw_s2_q, raw_s3_q;
  logic [NUM_PINS-1:0] clr_mask;
  logic [NUM_PINS-1:0] edge_ev, level_ev, raw_ev, ev;
  logic [NUM_PINS-1:0] status_d;
  logic [NUM_PINS-1:0] en_any;

  // per-pin clear strobe from the status word of its bank
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_clr
    localparam int BANK = p / WORD_W;
    localparam int BIT  = p % WORD_W;
    assign clr_mask[p] = wr && (widx == IDX_W'(STATUS_WORD + BANK)) && wdata[BIT];
  end

  always_comb begin
    edge_ev  = (en[K_RISE] & pin_sync & ~lvl_prev_q)
             | (en[K_FALL] & ~pin_sync & lvl_prev_q);
    level_ev = (en[K_HIGH] & pin_sync) | (en[K_LOW] & ~pin_sync);
    raw_ev   = (en[K_ARISE] & raw_s2_q & ~raw_s3_q)
             | (en[K_AFALL] & ~raw_s2_q & raw_s3_q);
    ev       = edge_ev | level_ev | raw_ev;
    status_d = (status_q & ~clr_mask) | ev;
    en_any   = '0;
    for (int k = 0; k < NUM_KINDS; k++) en_any = en_any | en[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev_q <= '0;
      raw_s1_q   <= '0;
      raw_s2_q   <= '0;
      raw_s3_q   <= '0;
      status_q   <= '0;
    end else begin
      lvl_prev_q <= pin_sync;
      raw_s1_q   <= pin_raw;
      raw_s2_q   <= raw_s1_q;
      raw_s3_q   <= raw_s2_q;
      status_q   <= status_d;
    end
  end

  // R12
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(en_any)) == '0));

  // R4
  w1c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status_q & $past(status_q) & ~$past(clr_mask)) == '0));

  // R5
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(level_ev)) == $past(level_ev)));
endmodule

// File: rtl/gev_irq_group.sv
module gev_irq_group #(
  parameter int NUM_PINS   = 54,
  parameter int G1_FIRST   = 28,
  parameter int G2_FIRST   = 46,
  parameter int NUM_GROUPS = 3
) (
  input  logic [NUM_PINS-1:0]   status,
  output logic [NUM_GROUPS-1:0] irq
);
  function automatic logic [NUM_PINS-1:0] range_mask(input int lo, input int hi);
    logic [NUM_PINS-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_PINS; i++) if (i >= lo && i <= hi) m[i] = 1'b1;
    return m;
  endfunction

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int LO = (g == 0) ? 0 : (g == 1) ? G1_FIRST : G2_FIRST;
    localparam int HI = (g == 0) ? G1_FIRST - 1 : (g == 1) ? G2_FIRST - 1 : NUM_PINS - 1;
    localparam logic [NUM_PINS-1:0] MASK = range_mask(LO, HI);
    assign irq[g] = |(status & MASK);
  end
endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit
  import gev_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8,
  parameter int G1_FIRST = 28,
  parameter int G2_FIRST = 46
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_sync,
  input  logic [NUM_PINS-1:0] pin_raw,
  output logic [2:0]          irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int PAD_W = BANKS * WORD_W;

  logic                               rst_s1_q, rst_q;
  logic [IDX_W-1:0]                   widx;
  logic                               unused_lsb;
  logic [NUM_KINDS-1:0][NUM_PINS-1:0] en_q;
  logic [NUM_PINS-1:0]                status_q;
  logic [PAD_W-1:0]                   stat_pad;
  logic [NUM_KINDS-1:0][PAD_W-1:0]    en_pad;

  // reset: asynchronous assert, two-flop synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_q    <= rst_s1_q;
    end
  end

  assign widx       = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];

  gev_enable_regs #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_q),
    .wr    (bus_wr),
    .widx  (widx),
    .wdata (bus_wdata),
    .en_q  (en_q)
  );

  gev_detect #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_detect (
    .clk      (clk),
    .rst_n    (rst_q),
    .en       (en_q),
    .pin_sync (pin_sync),
    .pin_raw  (pin_raw),
    .wr       (bus_wr),
    .widx     (widx),
    .wdata    (bus_wdata),
    .status_q (status_q)
  );

  gev_irq_group #(.NUM_PINS(NUM_PINS), .G1_FIRST(G1_FIRST), .G2_FIRST(G2_FIRST),
                  .NUM_GROUPS(3)) u_irq (
    .status (status_q),
    .irq    (irq)
  );

  // read decode
  always_comb begin
    stat_pad                 = '0;
    stat_pad[NUM_PINS-1:0]   = status_q;
    for (int k = 0; k < NUM_KINDS; k++) begin
      en_pad[k]                = '0;
      en_pad[k][NUM_PINS-1:0]  = en_q[k];
    end
    bus_rdata = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (widx == IDX_W'(STATUS_WORD + b)) bus_rdata = stat_pad[b*WORD_W +: WORD_W];
      for (int k = 0; k < NUM_KINDS; k++) begin
        if (widx == IDX_W'(enable_word(k, b))) bus_rdata = en_pad[k][b*WORD_W +: WORD_W];
      end
    end
  end

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (status_q == '0) |-> (irq == 3'b000));
endmodule

// File: tb/gpio_event_unit_test.sv
module gpio_event_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [53:0] pin_sync;
  logic [53:0] pin_raw;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  gpio_event_unit uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_sync  (pin_sync),
    .pin_raw   (pin_raw),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic chk_reg(input string req, input string what,
                         input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, what, v, exp);
  endtask

  task automatic chk_irq(input string req, input logic [2:0] exp);
    check(req, "irq", {29'd0, irq}, {29'd0, exp});
  endtask

  task automatic clear_all();
    for (int a = 8'h4C; a <= 8'h8C; a += 4) wr(8'(a), 32'h0);
    pin_sync = '0; pin_raw = '0;
    repeat (4) step();
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    chk_reg("R10", "status0", 8'h40, 32'h0);
    chk_reg("R10", "status1", 8'h44, 32'h0);
    for (int a = 8'h4C; a <= 8'h8C; a += 4) chk_reg("R10", "enable", 8'(a), 32'h0);
    chk_irq("R10", 3'b000);
  endtask

  task automatic t_rise();
    pin_sync[4] = 1'b1;
    step();
    wr(8'h4C, 32'h18);
    pin_sync[3] = 1'b1; pin_sync[4] = 1'b0;
    step();
    chk_reg("R1", "rise only pin3", 8'h40, 32'h8);
    chk_irq("R1", 3'b001);
    clear_all();
  endtask

  task automatic t_fall();
    pin_sync[40] = 1'b1;
    step();
    wr(8'h5C, 32'h100);
    chk_reg("R2", "no event before fall", 8'h44, 32'h0);
    pin_sync[40] = 1'b0;
    step();
    chk_reg("R2", "fall pin40", 8'h44, 32'h100);
    chk_irq("R2", 3'b010);
    clear_all();
  endtask

  task automatic t_both();
    wr(8'h50, 32'h4_0000);
    wr(8'h5C, 32'h4_0000);
    pin_sync[50] = 1'b1;
    step();
    chk_reg("R3", "rise pin50", 8'h44, 32'h4_0000);
    chk_irq("R3", 3'b100);
    wr(8'h44, 32'h4_0000);
    chk_reg("R3", "cleared", 8'h44, 32'h0);
    pin_sync[50] = 1'b0;
    step();
    chk_reg("R3", "fall pin50", 8'h44, 32'h4_0000);
    // R4: write-one-to-clear
    wr(8'h44, 32'h0);
    chk_reg("R4", "zero write keeps", 8'h44, 32'h4_0000);
    wr(8'h44, 32'hFFFB_FFFF);
    chk_reg("R4", "other ones keep", 8'h44, 32'h4_0000);
    wr(8'h44, 32'h4_0000);
    chk_reg("R4", "one clears", 8'h44, 32'h0);
    chk_irq("R4", 3'b000);
    clear_all();
  endtask

  task automatic t_level();
    wr(8'h64, 32'h2000_0000);
    pin_sync[29] = 1'b1;
    step();
    chk_reg("R5", "high pin29", 8'h40, 32'h2000_0000);
    chk_irq("R5", 3'b010);
    wr(8'h40, 32'h2000_0000);
    chk_reg("R5", "clear while high ignored", 8'h40, 32'h2000_0000);
    pin_sync[29] = 1'b0;
    step();
    chk_reg("R5", "held after level gone", 8'h40, 32'h2000_0000);
    wr(8'h40, 32'h2000_0000);
    chk_reg("R5", "clear after level gone", 8'h40, 32'h0);
    wr(8'h74, 32'h2000);
    step();
    chk_reg("R5", "low pin45", 8'h44, 32'h2000);
    chk_irq("R5", 3'b010);
    pin_sync[45] = 1'b1;
    step();
    wr(8'h44, 32'h2000);
    chk_reg("R5", "low cleared", 8'h44, 32'h0);
    clear_all();
  endtask

  task automatic t_async();
    wr(8'h80, 32'h4000);
    pin_raw[46] = 1'b1;
    step();
    chk_reg("R6", "raw rise edge1", 8'h44, 32'h0);
    step();
    step();
    chk_reg("R6", "raw rise edge3", 8'h44, 32'h4000);
    chk_irq("R6", 3'b100);
    pin_raw[27] = 1'b1;
    repeat (3) step();
    wr(8'h88, 32'h0800_0000);
    chk_reg("R6", "no fall yet", 8'h40, 32'h0);
    pin_raw[27] = 1'b0;
    step();
    chk_reg("R6", "raw fall edge1", 8'h40, 32'h0);
    step();
    step();
    chk_reg("R6", "raw fall edge3", 8'h40, 32'h0800_0000);
    chk_irq("R6", 3'b101);
    clear_all();
  endtask

  task automatic t_sticky();
    wr(8'h4C, 32'h20);
    pin_sync[5] = 1'b1;
    step();
    wr(8'h4C, 32'h0);
    repeat (3) step();
    chk_reg("R7", "sticky pin5", 8'h40, 32'h20);
    chk_irq("R7", 3'b001);
    clear_all();
  endtask

  task automatic t_groups();
    int pins [8] = '{0, 27, 28, 31, 32, 45, 46, 53};
    foreach (pins[i]) begin
      int p = pins[i];
      logic [7:0] ea = (p < 32) ? 8'h64 : 8'h68;
      logic [7:0] sa = (p < 32) ? 8'h40 : 8'h44;
      logic [2:0] exp_irq = (p < 28) ? 3'b001 : (p < 46) ? 3'b010 : 3'b100;
      wr(ea, 32'h1 << (p % 32));
      pin_sync[p] = 1'b1;
      step();
      chk_reg("R8", $sformatf("status pin%0d", p), sa, 32'h1 << (p % 32));
      chk_irq("R8", exp_irq);
      clear_all();
    end
  endtask

  task automatic t_collide();
    wr(8'h4C, 32'h40);
    pin_sync[6] = 1'b1;
    step();
    pin_sync[6] = 1'b0;
    step();
    pin_sync[6] = 1'b1;
    wr(8'h40, 32'h40);
    chk_reg("R9", "event beats clear", 8'h40, 32'h40);
    wr(8'h40, 32'h40);
    chk_reg("R9", "later clear", 8'h40, 32'h0);
    clear_all();
  endtask

  task automatic t_noenable();
    pin_sync = '1; pin_raw = '1;
    repeat (4) step();
    pin_sync = '0; pin_raw = '0;
    repeat (4) step();
    chk_reg("R12", "status0", 8'h40, 32'h0);
    chk_reg("R12", "status1", 8'h44, 32'h0);
    chk_irq("R12", 3'b000);
  endtask

  task automatic t_readback();
    wr(8'h50, 32'hFFFF_FFFF);
    chk_reg("R11", "upper bank masked", 8'h50, 32'h003F_FFFF);
    wr(8'h64, 32'hA5A5_A5A5);
    chk_reg("R11", "bank0 readback", 8'h64, 32'hA5A5_A5A5);
    chk_reg("R11", "other word untouched", 8'h68, 32'h0);
    chk_reg("R11", "unmapped", 8'h00, 32'h0);
    clear_all();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_sync = '0; pin_raw = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_async();
    t_sticky();
    t_groups();
    t_collide();
    t_noenable();
    t_readback();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule